// File: doc/BRIEF.md
# Pixel Clock Setting Search

This block turns a requested pixel clock, given in kHz, into the 12-bit setting word for a clock generator. The generator multiplies a fixed 12 MHz reference by an integer factor M in a PLL. It then divides the PLL output by an integer D and by a further fixed 2. The achievable pixel clock is therefore 6000·M/D kHz. The block walks every (M, D) pair, one pair per clock cycle. It drops the pairs that break a limit and keeps the pair whose clock lies nearest the request.

A controller loads the request and pulses `start`. `busy` stays high while the scan runs. Then `done` pulses for one cycle, and the packed word, the achieved frequency and a no-solution flag become valid. The word holds the PLL band code in bits 11:10, M in bits 9:4 and D in bits 3:0. The band code is derived from the chosen PLL frequency and is not supplied by the caller. The results stay unchanged until the next search completes.

Top module: `pclk_setting_search`

## Requirements
- R1: The result word places the band code in bits 11:10, the multiplier M in bits 9:4 and the divider D in bits 3:0.
- R2: Only candidates whose PLL frequency 12000·M kHz lies between 20000 kHz and 228000 kHz inclusive are eligible. With the default settings M is therefore 2 to 19.
- R3: Only candidates whose pixel clock 6000·M/D kHz does not exceed 96000 kHz are eligible. D ranges over 1 to 12.
- R4: The band code is 0 when the PLL frequency is at most 40000 kHz, 1 when it is at most 80000 kHz, 2 when it is at most 160000 kHz, and 3 above that. So 156 MHz gives 2 and 168 MHz gives 3.
- R5: Among the eligible candidates the block picks the one with the smallest |6000·M/D − request|. The comparison is made by cross-multiplying the scaled errors |6000·M − request·D| with the other candidate's divider, so no division is needed.
- R6: On a tie the earlier candidate is kept. The scan order is D ascending in the outer loop and M ascending in the inner loop, so a request of 54000 gives the word 0x891.
- R7: After `start` is sampled with the block idle, `busy` stays high and `done` rises exactly 229 clock edges later (228 candidates plus one result cycle). `done` is high for one cycle only, and never together with `busy`.
- R8: A `start` pulse or a change of the request while `busy` is high has no effect on the running search or on its result.
- R9: The word, the achieved frequency and the flag change only in the cycle where `done` is high. They hold between searches.
- R10: A request of 0, or a scan that finds no eligible candidate, yields `no_solution` = 1, a word of 0 and an achieved frequency of 0.
- R11: The achieved frequency output equals floor(6000·M/D) for the chosen pair.
- R12: After reset `busy`, `done` and `no_solution` are 0 and the word and the achieved frequency are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a search when the block is idle |
| req_khz | input | 17 | Requested pixel clock in kHz, sampled with start |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle pulse when the results are updated |
| reg_word | output | 12 | Packed setting: band, multiplier, divider |
| achieved_khz | output | 17 | Pixel clock of the chosen setting in kHz |
| no_solution | output | 1 | No eligible setting, or the request was zero |

## Verification
The assertions assume that `start` is a synchronous level sampled at a rising edge. They also assume that the request only matters in the cycle where `start` is accepted, so the scan counter and the result registers are judged only against the request latched at that point. The bench drives `start` and `req_khz` on falling edges and holds each for a full cycle. It deliberately toggles both during a scan to show that the latched copy is what counts, and it samples every output on falling edges. The expected words come from an independent brute-force model written in the bench from the requirement text.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
   localparam int BAND_W    = 2;
   localparam int NUM_EDGES = 3;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SCAN = 2'd1,
      ST_FIN  = 2'd2
   } scan_state_t;
endpackage

// File: rtl/pcs_scan_ctr.sv
module pcs_scan_ctr #(
   parameter int MUL_W   = 6,
   parameter int DIV_W   = 4,
   parameter int MUL_MAX = 19,
   parameter int DIV_MAX = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             step,
   output logic [MUL_W-1:0] mul,
   output logic [DIV_W-1:0] div,
   output logic             last
);
   localparam logic [MUL_W-1:0] M_LAST = MUL_W'(MUL_MAX);
   localparam logic [DIV_W-1:0] D_LAST = DIV_W'(DIV_MAX);
   localparam logic [MUL_W-1:0] M_ONE  = MUL_W'(1);
   localparam logic [DIV_W-1:0] D_ONE  = DIV_W'(1);

   if (MUL_MAX < 1 || MUL_MAX >= (1 << MUL_W)) begin : g_bad_mul
      $error("pcs_scan_ctr: MUL_MAX does not fit MUL_W");
   end
   if (DIV_MAX < 1 || DIV_MAX >= (1 << DIV_W)) begin : g_bad_div
      $error("pcs_scan_ctr: DIV_MAX does not fit DIV_W");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mul <= M_ONE;
         div <= D_ONE;
      end else if (load) begin
         mul <= M_ONE;
         div <= D_ONE;
      end else if (step) begin
         if (mul == M_LAST) begin
            mul <= M_ONE;
            div <= (div == D_LAST) ? D_ONE : div + D_ONE;
         end else begin
            mul <= mul + M_ONE;
         end
      end
   end

   assign last = (mul == M_LAST) && (div == D_LAST);

   // R7: the scan position never leaves the candidate grid
   p_ctr_bounds_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mul >= M_ONE) && (mul <= M_LAST) && (div >= D_ONE) && (div <= D_LAST));

   // R6: inner loop advances the multiplier while the divider holds
   p_inner_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && mul != M_LAST) |=> (div == $past(div)));
endmodule

// File: rtl/pcs_band_enc.sv
module pcs_band_enc #(
   parameter int          PLL_W = 24,
   parameter int unsigned EDGE0 = 40000,
   parameter int unsigned EDGE1 = 80000,
   parameter int unsigned EDGE2 = 160000
) (
   input  logic [PLL_W-1:0]          pll_khz,
   output logic [pcs_pkg::BAND_W-1:0] band
);
   localparam int unsigned EDGES [pcs_pkg::NUM_EDGES] = '{EDGE0, EDGE1, EDGE2};

   if (!(EDGE0 < EDGE1 && EDGE1 < EDGE2)) begin : g_bad_edges
      $error("pcs_band_enc: band edges must ascend");
   end

   logic [pcs_pkg::NUM_EDGES-1:0] above;

   for (genvar i = 0; i < pcs_pkg::NUM_EDGES; i++) begin : g_edge
      // an edge value itself stays in the lower band
      assign above[i] = (pll_khz > PLL_W'(EDGES[i]));
   end

   always_comb begin
      band = '0;
      for (int i = 0; i < pcs_pkg::NUM_EDGES; i++) begin
         band = band + pcs_pkg::BAND_W'(above[i]);
      end
   end
endmodule

// File: rtl/pcs_cand_eval.sv
module pcs_cand_eval #(
   parameter int MUL_W       = 6,
   parameter int DIV_W       = 4,
   parameter int REQ_W       = 17,
   parameter int ERR_W       = 23,
   parameter int UNIT_KHZ    = 6000,
   parameter int PLL_MIN_KHZ = 20000,
   parameter int PLL_MAX_KHZ = 228000,
   parameter int PIX_MAX_KHZ = 96000
) (
   input  logic [MUL_W-1:0] mul,
   input  logic [DIV_W-1:0] div,
   input  logic [REQ_W-1:0] req,
   input  logic             have_best,
   input  logic [ERR_W-1:0] best_err,
   input  logic [DIV_W-1:0] best_div,
   output logic             take,
   output logic [ERR_W-1:0] err
);
   localparam int XW = ERR_W + DIV_W;
   localparam int PW = ERR_W + 1;

   logic [ERR_W-1:0] scaled_clk;
   logic [ERR_W-1:0] scaled_req;
   logic [PW-1:0]    pll_khz;
   logic [ERR_W-1:0] pix_cap;
   logic             valid;
   logic [XW-1:0]    cross_new;
   logic [XW-1:0]    cross_old;
   logic             closer;

   assign scaled_clk = ERR_W'(mul) * ERR_W'(UNIT_KHZ);
   assign scaled_req = ERR_W'(req) * ERR_W'(div);
   assign pll_khz    = PW'(scaled_clk) << 1;
   assign pix_cap    = ERR_W'(PIX_MAX_KHZ) * ERR_W'(div);

   assign valid = (div != '0)
               && (pll_khz >= PW'(PLL_MIN_KHZ))
               && (pll_khz <= PW'(PLL_MAX_KHZ))
               && (scaled_clk <= pix_cap);

   assign err = (scaled_clk >= scaled_req) ? (scaled_clk - scaled_req)
                                           : (scaled_req - scaled_clk);

   // err/div against best_err/best_div without dividing
   assign cross_new = XW'(err) * XW'(best_div);
   assign cross_old = XW'(best_err) * XW'(div);
   assign closer    = !have_best || (cross_new < cross_old);

   assign take = valid && closer;
endmodule

// File: rtl/pclk_setting_search.sv
module pclk_setting_search #(
   parameter int REQ_W       = 17,
   parameter int MUL_W       = 6,
   parameter int DIV_W       = 4,
   parameter int MUL_MAX     = 19,
   parameter int DIV_MAX     = 12,
   parameter int REF_KHZ     = 12000,
   parameter int PLL_MIN_KHZ = 20000,
   parameter int PLL_MAX_KHZ = 228000,
   parameter int PIX_MAX_KHZ = 96000
) (
   input  logic                                     clk,
   input  logic                                     rst_n,
   input  logic                                     start,
   input  logic [REQ_W-1:0]                         req_khz,
   output logic                                     busy,
   output logic                                     done,
   output logic [pcs_pkg::BAND_W+MUL_W+DIV_W-1:0]   reg_word,
   output logic [REQ_W-1:0]                         achieved_khz,
   output logic                                     no_solution
);
   import pcs_pkg::*;

   localparam int WORD_W   = BAND_W + MUL_W + DIV_W;
   localparam int UNIT_KHZ = REF_KHZ / 2;
   localparam int ERR_W    = REQ_W + DIV_W + 2;
   localparam int PW       = ERR_W + 1;

   if (REF_KHZ % 2 != 0) begin : g_bad_ref
      $error("pclk_setting_search: REF_KHZ must be even");
   end
   if (longint'(UNIT_KHZ) * MUL_MAX >= (longint'(1) << ERR_W)) begin : g_bad_err_w
      $error("pclk_setting_search: scaled clock overflows ERR_W");
   end
   if (longint'(PIX_MAX_KHZ) * DIV_MAX >= (longint'(1) << ERR_W)) begin : g_bad_cap_w
      $error("pclk_setting_search: pixel cap overflows ERR_W");
   end
   if (PIX_MAX_KHZ >= (1 << REQ_W)) begin : g_bad_req_w
      $error("pclk_setting_search: REQ_W too narrow for PIX_MAX_KHZ");
   end

   scan_state_t      state;
   logic [REQ_W-1:0] req_q;
   logic             have_best;
   logic [ERR_W-1:0] best_err;
   logic [MUL_W-1:0] best_mul;
   logic [DIV_W-1:0] best_div;
   logic [MUL_W-1:0] cur_mul;
   logic [DIV_W-1:0] cur_div;
   logic             cur_last;
   logic             take;
   logic [ERR_W-1:0] cur_err;
   logic             accept;
   logic             scanning;
   logic [PW-1:0]    best_pll;
   logic [BAND_W-1:0] best_band;
   logic [ERR_W-1:0] best_scaled;
   logic [ERR_W-1:0] best_freq;

   assign accept   = start && (state == ST_IDLE);
   assign scanning = (state == ST_SCAN);
   assign busy     = (state != ST_IDLE);

   pcs_scan_ctr #(
      .MUL_W(MUL_W), .DIV_W(DIV_W), .MUL_MAX(MUL_MAX), .DIV_MAX(DIV_MAX)
   ) u_ctr (
      .clk(clk), .rst_n(rst_n), .load(accept), .step(scanning),
      .mul(cur_mul), .div(cur_div), .last(cur_last)
   );

   pcs_cand_eval #(
      .MUL_W(MUL_W), .DIV_W(DIV_W), .REQ_W(REQ_W), .ERR_W(ERR_W),
      .UNIT_KHZ(UNIT_KHZ), .PLL_MIN_KHZ(PLL_MIN_KHZ),
      .PLL_MAX_KHZ(PLL_MAX_KHZ), .PIX_MAX_KHZ(PIX_MAX_KHZ)
   ) u_eval (
      .mul(cur_mul), .div(cur_div), .req(req_q),
      .have_best(have_best), .best_err(best_err), .best_div(best_div),
      .take(take), .err(cur_err)
   );

   assign best_pll = PW'(best_mul) * PW'(REF_KHZ);

   pcs_band_enc #(.PLL_W(PW)) u_band (
      .pll_khz(best_pll), .band(best_band)
   );

   assign best_scaled = ERR_W'(best_mul) * ERR_W'(UNIT_KHZ);
   assign best_freq   = (best_div != '0) ? best_scaled / ERR_W'(best_div) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         req_q     <= '0;
         have_best <= 1'b0;
         best_err  <= '0;
         best_mul  <= '0;
         best_div  <= '0;
      end else begin
         case (state)
            ST_IDLE: if (accept) begin
               state     <= ST_SCAN;
               req_q     <= req_khz;
               have_best <= 1'b0;
            end
            ST_SCAN: begin
               if (take) begin
                  have_best <= 1'b1;
                  best_err  <= cur_err;
                  best_mul  <= cur_mul;
                  best_div  <= cur_div;
               end
               if (cur_last) state <= ST_FIN;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done         <= 1'b0;
         reg_word     <= '0;
         achieved_khz <= '0;
         no_solution  <= 1'b0;
      end else begin
         done <= (state == ST_FIN);
         if (state == ST_FIN) begin
            if (have_best && req_q != '0) begin
               reg_word     <= {best_band, best_mul, best_div};
               achieved_khz <= REQ_W'(best_freq);
               no_solution  <= 1'b0;
            end else begin
               reg_word     <= '0;
               achieved_khz <= '0;
               no_solution  <= 1'b1;
            end
         end
      end
   end

   // R7: done is a single-cycle pulse
   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7: done and busy never overlap
   p_busy_done_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && busy));

   // R8: a running scan is not restarted by start
   p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (scanning && !cur_last) |=> (scanning && $stable(req_q)));

   // R9: results move only with done
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(reg_word) && $stable(achieved_khz) && $stable(no_solution)));

   // R10: the no-solution flag comes with an all-zero result
   p_nosol_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      no_solution |-> (reg_word == '0 && achieved_khz == '0));

   // R2 and R3: a reported pair lies inside the searched limits
   p_fields_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !no_solution) |->
         (reg_word[DIV_W-1:0] != '0) && (reg_word[DIV_W-1:0] <= DIV_W'(DIV_MAX))
         && (reg_word[DIV_W+MUL_W-1:DIV_W] <= MUL_W'(MUL_MAX))
         && (achieved_khz <= REQ_W'(PIX_MAX_KHZ)));
endmodule

// File: tb/tb_pclk_setting_search.sv
module tb_pclk_setting_search;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [16:0] req_khz = '0;
   logic        busy;
   logic        done;
   logic [11:0] reg_word;
   logic [16:0] achieved_khz;
   logic        no_solution;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   pclk_setting_search dut (
      .clk(clk), .rst_n(rst_n), .start(start), .req_khz(req_khz),
      .busy(busy), .done(done), .reg_word(reg_word),
      .achieved_khz(achieved_khz), .no_solution(no_solution)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // brute-force model built from R2..R6, R10, R11
   task automatic model(input int f, output int word, output int ach, output int nos);
      int bm = 0, bd = 0, be = 0, band;
      for (int d = 1; d <= 12; d++) begin
         for (int m = 1; m <= 19; m++) begin
            int pll = 12000 * m;
            int e;
            if (pll < 20000 || pll > 228000) continue;
            if (6000 * m > 96000 * d) continue;
            e = (6000 * m > f * d) ? 6000 * m - f * d : f * d - 6000 * m;
            if (bd == 0 || longint'(e) * bd < longint'(be) * d) begin
               bm = m; bd = d; be = e;
            end
         end
      end
      if (f == 0 || bd == 0) begin
         word = 0; ach = 0; nos = 1;
      end else begin
         band = (12000 * bm <= 40000) ? 0 : (12000 * bm <= 80000) ? 1 :
                (12000 * bm <= 160000) ? 2 : 3;
         word = (band << 10) | (bm << 4) | bd;
         ach  = (6000 * bm) / bd;
         nos  = 0;
      end
   endtask

   // runs one search, returns the latency in edges after the start edge
   task automatic search(input int f, output int lat);
      @(negedge clk);
      req_khz = 17'(f);
      start   = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 0;
      while (!done && lat < 400) begin
         @(negedge clk);
         lat++;
      end
   endtask

   task automatic t_reset;
      chk("R12 busy", int'(busy), 0);
      chk("R12 done", int'(done), 0);
      chk("R12 word", int'(reg_word), 0);
      chk("R12 achieved", int'(achieved_khz), 0);
      chk("R12 no_solution", int'(no_solution), 0);
   endtask

   task automatic t_known(input int f, input int exp_word, input string tag);
      int lat, w, a, n;
      search(f, lat);
      model(f, w, a, n);
      chk({tag, " word"}, int'(reg_word), exp_word);
      chk({tag, " model word"}, int'(reg_word), w);
      chk("R11 achieved", int'(achieved_khz), a);
   endtask

   task automatic t_latency;
      int lat;
      @(negedge clk);
      req_khz = 17'd60000;
      start   = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R7 busy after start", int'(busy), 1);
      lat = 0;
      while (!done && lat < 400) begin
         @(negedge clk);
         lat++;
      end
      chk("R7 latency", lat, 229);
      chk("R7 busy low with done", int'(busy), 0);
      @(negedge clk);
      chk("R7 done one cycle", int'(done), 0);
      chk("R1 word 60000", int'(reg_word), 12'h8A1);
   endtask

   task automatic t_busy_ignore;
      int lat;
      @(negedge clk);
      req_khz = 17'd84000;
      start   = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 0;
      repeat (20) begin @(negedge clk); lat++; end
      req_khz = 17'd1;
      start   = 1'b1;
      @(negedge clk); lat++;
      start = 1'b0;
      chk("R9 word held while busy", int'(reg_word), 12'h8A1);
      while (!done && lat < 400) begin
         @(negedge clk);
         lat++;
      end
      chk("R8 latency unchanged", lat, 229);
      chk("R8 result of first request", int'(reg_word), 12'hCE1);
   endtask

   task automatic t_zero;
      int lat;
      search(0, lat);
      chk("R10 flag", int'(no_solution), 1);
      chk("R10 word", int'(reg_word), 0);
      chk("R10 achieved", int'(achieved_khz), 0);
      repeat (5) @(negedge clk);
      chk("R9 hold flag", int'(no_solution), 1);
   endtask

   task automatic t_sweep;
      int reqs [8] = '{71000, 100000, 1, 25000, 33333, 48500, 13000, 120000};
      foreach (reqs[i]) begin
         int lat, w, a, n;
         search(reqs[i], lat);
         model(reqs[i], w, a, n);
         chk("R5 nearest word", int'(reg_word), w);
         chk("R11 nearest achieved", int'(achieved_khz), a);
         chk("R10 flag clear", int'(no_solution), n);
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_known(54000, 12'h891, "R6 tie");
      t_known(72000, 12'h8C1, "R1");
      t_known(96000, 12'hD01, "R3 pixel cap");
      t_known(78000, 12'h8D1, "R4 156MHz");
      t_known(84000, 12'hCE1, "R4 168MHz");
      t_known(57000, 12'hD32, "R2 pll ceiling");
      t_known(1, 12'h02C, "R2 lowest");
      t_latency();
      t_busy_ignore();
      t_zero();
      t_sweep();
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule